// File: doc/BRIEF.md
# SAR conversion sequencer

This block is the digital controller for a 13-bit successive-approximation converter. It runs the sample-and-hold switch and the trial bits of the capacitor DAC. It reads one comparator decision per trial and delivers one result code per conversion, marked by a single-cycle valid strobe. The analog parts (comparator, DAC, reference and input selection) sit outside the block.

A conversion frame lasts 15 conversion-clock ticks. The first two ticks hold the input and the next thirteen decide the bits, most significant first. A 3-bit rate select sets how often a tick occurs, counted against a 16 MHz base clock. Select 0 stops the converter. Three further inputs shape the result:
- A mode input chooses differential or single-ended operation. In single-ended operation the code runs the opposite way to the input.
- A calibration input swaps the comparator's two inputs, which inverts every decision.
- An enable input starts and stops conversions.

After each start the block spends one tick clearing state and one tick applying the new settings. It then holds back the first three results, which cannot be trusted.

Top module: `sar_seq`

## Requirements
- R1: A frame is 2 sample ticks followed by 13 trial ticks. `sampleHold` is high for exactly 2 ticks of base cycles per frame, and `dacBits` is all zero whenever `sampleHold` is high.
- R2: `clkSel` sets the tick period in base cycles. Values 4, 5, 6 and 7 give 1, 2, 4 and 16. Values 1, 2 and 3 give SLOW_DIV, 2·SLOW_DIV and 4·SLOW_DIV, where the default SLOW_DIV of 1000 gives 16, 8 and 4 kHz from 16 MHz. Successive valid strobes are therefore 15 ticks apart.
- R3: Trials run from bit 12 down to bit 0. During a trial, `dacBits` is the bits kept so far with the trial bit set. `cmpIn`=1 means the DAC level is at or below the held input, and the trial bit is then kept. With `singleEnded`=0 and `calSwap`=0, an ideal comparator gives a code equal to the input value.
- R4: With `singleEnded`=1 the code is the bitwise inverse of the decided bits, so an ideal comparator gives 8191 minus the input.
- R5: With `calSwap`=1 every comparator decision is inverted before it is used. This applies in both modes.
- R6: After the converter starts (enable high with `clkSel` nonzero), it spends one tick clearing and one tick applying, then drops the first three results. The first valid strobe comes after exactly 63 ticks.
- R7: One clock after `enable` falls, `sampleHold`=0 and `dacBits`=0, and no valid strobe follows. A restart repeats the full 63-tick warm-up.
- R8: While `clkSel`=0 the sequencer stays idle: no sampling and no valid strobe.
- R9: After reset, `sampleHold`, `dacBits`, `code` and `codeValid` are all zero.
- R10: `codeValid` is high for one cycle per result, and `code` holds its value until the next result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 16 MHz base clock |
| rstN | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Run request |
| singleEnded | input | 1 | 1 = single-ended (inverted code), 0 = differential |
| calSwap | input | 1 | 1 = comparator inputs swapped for offset calibration |
| clkSel | input | 3 | Conversion rate select |
| cmpIn | input | 1 | Comparator: 1 = DAC level at or below held input |
| sampleHold | output | 1 | Sample switch closed |
| dacBits | output | 13 | DAC trial word |
| code | output | 13 | Last reported conversion result |
| codeValid | output | 1 | One-cycle strobe for a new result |

## Verification
The bench keeps DATA_W at its default of 13. It sweeps the full input range 0 to 8191 at a stride of 11, always including both end codes, once for each of the four combinations of mode and swap. It sets SLOW_DIV to 5, so all three slow rate selects finish a frame within a few hundred cycles. This lets every `clkSel` value have its frame period and sample width measured, where the default divisors would make that too slow. Warm-up length is measured at several rates and again after an abort in mid-trial.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CLR,
    ST_APPLY,
    ST_SAMP,
    ST_CONV
  } seqState_t;

  // Strobes passed from the control FSM to the datapath.
  typedef struct packed {
    logic clear;   // drop trial state
    logic load;    // start trials at the MSB
    logic decide;  // resolve the current trial bit
    logic finish;  // this decide is the last of the frame
    logic report;  // publish the result
  } seqStrobe_t;

endpackage

// File: rtl/sar_seq_clkdiv.sv
module sar_seq_clkdiv #(
  parameter int SLOW_DIV = 1000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic [2:0] clkSel,
  output logic       run,
  output logic       tick
);
  localparam int MAX_DIV = (4 * SLOW_DIV > 16) ? 4 * SLOW_DIV : 16;
  localparam int CNT_W   = $clog2(MAX_DIV + 1);

  logic [CNT_W-1:0] divVal;
  logic [CNT_W-1:0] cnt;

  always_comb begin
    case (clkSel)
      3'd1:    divVal = CNT_W'(SLOW_DIV);
      3'd2:    divVal = CNT_W'(2 * SLOW_DIV);
      3'd3:    divVal = CNT_W'(4 * SLOW_DIV);
      3'd4:    divVal = CNT_W'(1);
      3'd5:    divVal = CNT_W'(2);
      3'd6:    divVal = CNT_W'(4);
      3'd7:    divVal = CNT_W'(16);
      default: divVal = '0;
    endcase
  end

  assign run  = enable && (divVal != '0);
  // ">=" lets a select change to a shorter period recover at once.
  assign tick = run && (cnt >= divVal - CNT_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             cnt <= '0;
    else if (!run || tick) cnt <= '0;
    else                   cnt <= cnt + CNT_W'(1);
  end
endmodule

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
  import sar_seq_pkg::*;
#(
  parameter int DATA_W       = 13,
  parameter int SAMPLE_TICKS = 2,
  parameter int WARMUP_DROP  = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       run,
  input  logic       tick,
  output seqStrobe_t strobe,
  output logic       sampling
);
  localparam int BIT_W  = $clog2(DATA_W);
  localparam int PH_W   = $clog2(SAMPLE_TICKS + 1);
  localparam int DROP_W = $clog2(WARMUP_DROP + 1);

  seqState_t         state;
  logic [PH_W-1:0]   phaseCnt;
  logic [BIT_W-1:0]  bitIdx;
  logic [DROP_W-1:0] dropCnt;

  logic lastSample, lastBit, warmDone;
  assign lastSample = (phaseCnt == PH_W'(SAMPLE_TICKS - 1));
  assign lastBit    = (bitIdx == '0);
  assign warmDone   = (dropCnt == DROP_W'(WARMUP_DROP));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      phaseCnt <= '0;
      bitIdx   <= '0;
      dropCnt  <= '0;
    end else if (!run) begin
      state    <= ST_IDLE;
      phaseCnt <= '0;
      bitIdx   <= '0;
      dropCnt  <= '0;
    end else if (tick) begin
      case (state)
        ST_IDLE:  state <= ST_CLR;
        ST_CLR:   state <= ST_APPLY;
        ST_APPLY: begin
          state    <= ST_SAMP;
          phaseCnt <= '0;
        end
        ST_SAMP: begin
          if (lastSample) begin
            state  <= ST_CONV;
            bitIdx <= BIT_W'(DATA_W - 1);
          end else begin
            phaseCnt <= phaseCnt + PH_W'(1);
          end
        end
        ST_CONV: begin
          if (lastBit) begin
            state    <= ST_SAMP;
            phaseCnt <= '0;
            if (!warmDone) dropCnt <= dropCnt + DROP_W'(1);
          end else begin
            bitIdx <= bitIdx - BIT_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.clear  = !run || (tick && state == ST_CLR);
    strobe.load   = tick && state == ST_SAMP && lastSample;
    strobe.decide = tick && state == ST_CONV;
    strobe.finish = strobe.decide && lastBit;
    strobe.report = strobe.finish && warmDone;
  end

  assign sampling = (state == ST_SAMP);
endmodule

// File: rtl/sar_seq_dpath.sv
module sar_seq_dpath
  import sar_seq_pkg::*;
#(
  parameter int DATA_W = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic              cmpIn,
  input  logic              singleEnded,
  input  logic              calSwap,
  output logic [DATA_W-1:0] dacBits,
  output logic [DATA_W-1:0] code,
  output logic              codeValid
);
  localparam logic [DATA_W-1:0] MSB_ONE = {1'b1, {(DATA_W-1){1'b0}}};

  logic [DATA_W-1:0] sarReg, trialMask, decided;
  logic keepBit;

  // A swapped comparator reports the opposite sense.
  assign keepBit = cmpIn ^ calSwap;

  for (genvar j = 0; j < DATA_W; j++) begin : g_bit
    assign decided[j] = (strobe.decide && trialMask[j]) ? keepBit : sarReg[j];
  end

  assign dacBits = sarReg | trialMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sarReg    <= '0;
      trialMask <= '0;
      code      <= '0;
      codeValid <= 1'b0;
    end else begin
      codeValid <= strobe.report;
      if (strobe.report) code <= singleEnded ? ~decided : decided;
      if (strobe.clear || strobe.finish) begin
        sarReg    <= '0;
        trialMask <= '0;
      end else if (strobe.load) begin
        sarReg    <= '0;
        trialMask <= MSB_ONE;
      end else if (strobe.decide) begin
        sarReg    <= decided;
        trialMask <= trialMask >> 1;
      end
    end
  end
endmodule

// File: rtl/sar_seq.sv
module sar_seq
  import sar_seq_pkg::*;
#(
  parameter int DATA_W       = 13,
  parameter int SAMPLE_TICKS = 2,
  parameter int WARMUP_DROP  = 3,
  parameter int SLOW_DIV     = 1000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              singleEnded,
  input  logic              calSwap,
  input  logic [2:0]        clkSel,
  input  logic              cmpIn,
  output logic              sampleHold,
  output logic [DATA_W-1:0] dacBits,
  output logic [DATA_W-1:0] code,
  output logic              codeValid
);
  logic       run, tick;
  seqStrobe_t strobe;

  sar_seq_clkdiv #(.SLOW_DIV(SLOW_DIV)) u_div (
    .clk(clk), .rstN(rstN), .enable(enable), .clkSel(clkSel),
    .run(run), .tick(tick)
  );

  sar_seq_ctrl #(
    .DATA_W(DATA_W), .SAMPLE_TICKS(SAMPLE_TICKS), .WARMUP_DROP(WARMUP_DROP)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .run(run), .tick(tick),
    .strobe(strobe), .sampling(sampleHold)
  );

  sar_seq_dpath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cmpIn(cmpIn),
    .singleEnded(singleEnded), .calSwap(calSwap),
    .dacBits(dacBits), .code(code), .codeValid(codeValid)
  );
endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
  parameter int DATA_W       = 13,
  parameter int SAMPLE_TICKS = 2,
  parameter int WARMUP_DROP  = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              enable,
  input logic [2:0]        clkSel,
  input logic              sampleHold,
  input logic [DATA_W-1:0] dacBits,
  input logic              codeValid
);
  // Fewest base cycles from start to first report (one-cycle ticks).
  localparam int WARM_MIN = 2 + SAMPLE_TICKS + (SAMPLE_TICKS + DATA_W) * (WARMUP_DROP + 1) - SAMPLE_TICKS + 1;
  localparam int RC_W     = $clog2(WARM_MIN + 1);

  logic [RC_W-1:0] runCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          runCnt <= '0;
    else if (!enable || clkSel == 3'd0) runCnt <= '0;
    else if (runCnt < RC_W'(WARM_MIN))  runCnt <= runCnt + RC_W'(1);
  end

  p_sample_no_trial_r1: assert property (@(posedge clk) disable iff (!rstN)
    sampleHold |-> dacBits == '0);

  p_warmup_r6: assert property (@(posedge clk) disable iff (!rstN)
    codeValid |-> runCnt >= RC_W'(WARM_MIN));

  p_disable_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (!sampleHold && dacBits == '0 && !codeValid));

  p_sel_zero_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    clkSel == 3'd0 |=> (!sampleHold && !codeValid));

  p_valid_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    codeValid |=> !codeValid);
endmodule

bind sar_seq sar_seq_chk #(
  .DATA_W(DATA_W), .SAMPLE_TICKS(SAMPLE_TICKS), .WARMUP_DROP(WARMUP_DROP)
) u_chk (
  .clk(clk), .rstN(rstN), .enable(enable), .clkSel(clkSel),
  .sampleHold(sampleHold), .dacBits(dacBits), .codeValid(codeValid)
);

// File: tb/sim_sar_seq.sv
`timescale 1ns/1ps
module sim_sar_seq;
  localparam int W    = 13;
  localparam int SLOW = 5;
  localparam int MAXC = (1 << W) - 1;
  localparam int WARM = 63;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN, enable, singleEnded, calSwap;
  logic [2:0] clkSel;
  logic [W-1:0] stim;
  logic cmpIn, sampleHold, codeValid;
  logic [W-1:0] dacBits, code;

  // Ideal comparator against the stimulus value.
  assign cmpIn = (dacBits <= stim);

  sar_seq #(.SLOW_DIV(SLOW)) u0 (
    .clk(clk), .rstN(rstN), .enable(enable), .singleEnded(singleEnded),
    .calSwap(calSwap), .clkSel(clkSel), .cmpIn(cmpIn),
    .sampleHold(sampleHold), .dacBits(dacBits), .code(code), .codeValid(codeValid)
  );

  int nChecks = 0;
  int nFails  = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitValid(input int limit, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!codeValid && n < limit);
    if (!codeValid) n = -1;
  endtask

  // Decision inverted: bit kept when the trial level is above the input.
  function automatic int swapCode(input int s);
    int acc = 0;
    for (int b = W - 1; b >= 0; b--) begin
      int t = acc | (1 << b);
      if (t > s) acc = t;
    end
    return acc;
  endfunction

  function automatic int divOf(input int sel);
    case (sel)
      1: return SLOW;
      2: return 2 * SLOW;
      3: return 4 * SLOW;
      4: return 1;
      5: return 2;
      6: return 4;
      7: return 16;
      default: return 0;
    endcase
  endfunction

  task automatic stopRun();
    @(negedge clk);
    enable = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  // R2 / R1 / R6: warm-up, frame period and sample width for one select.
  task automatic measureSel(input int sel);
    int d, n, gap, hc;
    d = divOf(sel);
    stopRun();
    clkSel = 3'(sel);
    enable = 1'b1;
    waitValid(WARM * d + 20, n);
    check(n == WARM * d, "R6 warm-up cycles", n, WARM * d);
    hc = sampleHold;
    gap = 0;
    do begin
      @(negedge clk);
      gap++;
      if (!codeValid) hc += sampleHold;
    end while (!codeValid && gap < 20 * d);
    check(gap == 15 * d, "R2 frame period", gap, 15 * d);
    check(hc == 2 * d, "R1 sample width", hc, 2 * d);
  endtask

  task automatic runSweep(input bit se, input bit sw, input string req);
    int n, base, expv, s, held;
    stopRun();
    singleEnded = se;
    calSwap     = sw;
    clkSel      = 3'd4;
    stim        = '0;
    enable      = 1'b1;
    for (int i = 0; i <= MAXC / 11 + 1; i++) begin
      s = (i * 11 > MAXC) ? MAXC : i * 11;
      stim = W'(s);
      waitValid((i == 0) ? WARM + 20 : 40, n);
      base = sw ? swapCode(s) : s;
      expv = se ? MAXC - base : base;
      check(n > 0 && int'(code) == expv, req, int'(code), expv);
      if (i == 0) begin
        held = int'(code);
        @(negedge clk);
        check(!codeValid && int'(code) == held, "R10 pulse/hold", int'(codeValid), 0);
      end
    end
  endtask

  initial begin
    #(190000 * 5);
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    int n, cntV, cntS;
    rstN = 1'b0; enable = 1'b0; singleEnded = 1'b0; calSwap = 1'b0;
    clkSel = 3'd0; stim = '0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R9 reset state
    check(!sampleHold && dacBits == '0 && code == '0 && !codeValid,
          "R9 reset outputs", int'(dacBits) + int'(code), 0);

    // R8: enabled with clkSel 0 stays idle
    enable = 1'b1;
    cntV = 0; cntS = 0;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      cntV += codeValid;
      cntS += sampleHold;
    end
    check(cntV == 0 && cntS == 0, "R8 idle at select 0", cntV + cntS, 0);

    for (int sel = 1; sel <= 7; sel++) measureSel(sel);

    // R3, R4, R5: code sweeps in each mode combination
    runSweep(1'b0, 1'b0, "R3 differential code");
    runSweep(1'b1, 1'b0, "R4 single-ended code");
    runSweep(1'b0, 1'b1, "R5 swapped differential code");
    runSweep(1'b1, 1'b1, "R5 swapped single-ended code");

    // R7: abort in mid-trial, then restart
    stopRun();
    singleEnded = 1'b0; calSwap = 1'b0; clkSel = 3'd4; stim = W'(1234);
    enable = 1'b1;
    waitValid(WARM + 20, n);
    repeat (9) @(negedge clk);
    check(dacBits != '0, "R7 trial in progress", int'(dacBits), 1);
    enable = 1'b0;
    @(negedge clk);
    check(!sampleHold && dacBits == '0, "R7 idle after disable", int'(dacBits), 0);
    cntV = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      cntV += codeValid;
    end
    check(cntV == 0, "R7 no result after abort", cntV, 0);
    enable = 1'b1;
    waitValid(WARM + 20, n);
    check(n == WARM, "R7 full warm-up on restart", n, WARM);
    check(int'(code) == 1234, "R3 code after restart", int'(code), 1234);

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule